// File: doc/BRIEF.md
# Sixteen-Line GPIO Expander Register Core

This core is the register side of a serial-bus GPIO expander. It has sixteen general-purpose lines in two byte-wide ports. A host reaches the core through a byte-level register interface. That interface stands in for a serial transaction that has already been decoded: it carries a device address, a register index, read and write strobes and a data byte. The host sets each line as an input or an output, writes output latch values and chooses per-bit read inversion for inputs. It reads back every register, the live port values and an interrupt snapshot.

The core watches the sampled pins against the port state that the host last read. When any input-direction line disagrees, it pulls an active-low interrupt and raises a separate drive-enable, which together behave as an open-drain output. On the cycle the interrupt first asserts, a capture register records all sixteen sampled pins. A port read stores the current sample as the new port state, and this clears the interrupt. A three-bit strap gives the low address bits, so eight cores can share one bus.

Top module: `gpx_core`

## Requirements
- R1: After reset every line is an input (pin_oe all 0). The output latches, polarity, port state and capture registers are 0, irq_n is 1, irq_oe is 0 and host_rdata is 0.
- R2: A strobe is acted on only when host_addr equals {4'b0100, strap_addr}. Any other address writes nothing, updates no port state and leaves host_rdata unchanged.
- R3: Index 6 is the direction byte for lines 7..0 and index 7 is the direction byte for lines 15..8. A bit value of 1 means input (pin_oe bit 0) and 0 means output. pin_oe follows the write from the clock edge that accepts it.
- R4: Index 2 is the output latch for lines 7..0 and index 3 is the latch for lines 15..8. A write to index 0 or 1 also goes to that port's latch. pin_out always shows the latches.
- R5: A read of index 0 or 1 returns that port's pins, sampled through one register stage. Each input-direction bit is XORed with its polarity bit (index 4 or 5). Output-direction bits are never inverted.
- R6: Read data appears on host_rdata after the clock edge that accepts the read. It holds until the next accepted read. Indices 2 to 7 return the stored latch, polarity and direction bytes.
- R7: irq_n is 0 and irq_oe is 1 in the cycle after any edge where an input-direction line's sample differs from its stored port state. Lines set as outputs never cause an interrupt.
- R8: A read of index 0 or 1 stores that port's current sample as its port state. The interrupt releases unless another input still mismatches. A read of the capture indices does not release it.
- R9: On the edge where the interrupt goes from released to asserted, the capture registers (index 8 for lines 7..0, index 9 for lines 15..8) load the raw sampled pins, with no polarity applied. They hold at all other times.
- R10: Indices 10 to 15 read as 0. Writes to them, and writes to indices 8 and 9, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 3 | Low device address bits from board straps |
| host_addr | input | 7 | Device address of the current transaction |
| host_idx | input | 4 | Register index |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write data byte |
| host_rdata | output | 8 | Registered read data byte |
| pin_in | input | 16 | Pin values seen at the pads |
| pin_out | output | 16 | Output values for the pads |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| irq_n | output | 1 | Interrupt, active low |
| irq_oe | output | 1 | Interrupt pull-down enable (open-drain model) |

## Verification
The change detector is tried with three kinds of pin pattern. A single input line flips while its port is in sync, which shows whether the mismatch is taken per line and whether the snapshot is raw. A line that has been set as an output toggles, which shows whether the direction mask gates the interrupt. A mismatch is spread over both ports and only one port is read, which shows whether a partial read releases the interrupt too early. Random interleavings of reads, writes, foreign addresses and pin changes are then checked against a bench model. These separate read-then-clear ordering faults from sample-timing faults.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    // Register class, taken from the upper bits of the register index.
    typedef enum logic [2:0] {
        KIND_PORT = 3'd0,
        KIND_OLAT = 3'd1,
        KIND_POL  = 3'd2,
        KIND_DIR  = 3'd3,
        KIND_CAP  = 3'd4,
        KIND_NONE = 3'd7
    } gpx_kind_e;

endpackage

// File: rtl/gpx_decode.sv
module gpx_decode
    import gpx_pkg::*;
#(
    parameter int                 NPORTS    = 2,
    parameter int                 PSEL_W    = 1,
    parameter int                 IDX_W     = 4,
    parameter int                 STRAP_W   = 3,
    parameter int                 ADDR_HI_W = 4,
    parameter int                 ADDR_W    = 7,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b0100
) (
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic [IDX_W-1:0]   host_idx,
    input  logic               host_rd,
    input  logic               host_wr,
    output logic               rd_hit,
    output logic               wr_hit,
    output gpx_kind_e          kind,
    output logic [PSEL_W-1:0]  psel
);

    logic        addr_ok;
    logic [2:0]  kind_raw;

    // R2: only the strap-completed device address is served
    assign addr_ok  = (host_addr == {ADDR_HI, strap_addr});
    assign rd_hit   = host_rd && addr_ok;
    assign wr_hit   = host_wr && addr_ok;
    assign kind_raw = host_idx[IDX_W-1:PSEL_W];
    assign psel     = host_idx[PSEL_W-1:0];

    // R10: anything past the capture pair decodes as no register
    always_comb begin
        if (kind_raw <= 3'd4 && int'(psel) < NPORTS) begin
            kind = gpx_kind_e'(kind_raw);
        end else begin
            kind = KIND_NONE;
        end
    end

endmodule

// File: rtl/gpx_readmux.sv
module gpx_readmux
    import gpx_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int NPORTS = 2,
    parameter int PSEL_W = 1,
    parameter int LINES  = 16
) (
    input  gpx_kind_e          kind,
    input  logic [PSEL_W-1:0]  psel,
    input  logic [LINES-1:0]   in_s,
    input  logic [LINES-1:0]   pol,
    input  logic [LINES-1:0]   dir,
    input  logic [LINES-1:0]   olat,
    input  logic [LINES-1:0]   cap,
    output logic [PORT_W-1:0]  rd_byte
);

    always_comb begin
        rd_byte = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (psel == PSEL_W'(p)) begin
                case (kind)
                    // R5: inversion applies to input-direction bits only
                    KIND_PORT: rd_byte = in_s[p*PORT_W +: PORT_W]
                                       ^ (pol[p*PORT_W +: PORT_W] & dir[p*PORT_W +: PORT_W]);
                    KIND_OLAT: rd_byte = olat[p*PORT_W +: PORT_W];
                    KIND_POL:  rd_byte = pol[p*PORT_W +: PORT_W];
                    KIND_DIR:  rd_byte = dir[p*PORT_W +: PORT_W];
                    KIND_CAP:  rd_byte = cap[p*PORT_W +: PORT_W];
                    default:   rd_byte = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int                   PORT_W    = 8,
    parameter int                   NPORTS    = 2,
    parameter int                   STRAP_W   = 3,
    parameter int                   ADDR_HI_W = 4,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI   = 4'b0100
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [STRAP_W-1:0]                        strap_addr,
    input  logic [ADDR_HI_W+STRAP_W-1:0]              host_addr,
    input  logic [3+((NPORTS>1)?$clog2(NPORTS):1)-1:0] host_idx,
    input  logic                                      host_rd,
    input  logic                                      host_wr,
    input  logic [PORT_W-1:0]                         host_wdata,
    output logic [PORT_W-1:0]                         host_rdata,
    input  logic [PORT_W*NPORTS-1:0]                  pin_in,
    output logic [PORT_W*NPORTS-1:0]                  pin_out,
    output logic [PORT_W*NPORTS-1:0]                  pin_oe,
    output logic                                      irq_n,
    output logic                                      irq_oe
);

    localparam int LINES  = PORT_W * NPORTS;
    localparam int PSEL_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int IDX_W  = 3 + PSEL_W;
    localparam int ADDR_W = ADDR_HI_W + STRAP_W;

    typedef struct packed {
        logic [LINES-1:0]  dir;
        logic [LINES-1:0]  olat;
        logic [LINES-1:0]  pol;
        logic [LINES-1:0]  port;
        logic [LINES-1:0]  cap;
        logic [LINES-1:0]  in_s;
        logic              irq;
        logic [PORT_W-1:0] rdata;
    } state_t;

    state_t            st_d, st_q;
    logic              rd_hit, wr_hit;
    gpx_kind_e         kind;
    logic [PSEL_W-1:0] psel;
    logic [PORT_W-1:0] rd_byte;

    gpx_decode #(
        .NPORTS(NPORTS), .PSEL_W(PSEL_W), .IDX_W(IDX_W), .STRAP_W(STRAP_W),
        .ADDR_HI_W(ADDR_HI_W), .ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI)
    ) i_decode (
        .host_addr(host_addr), .strap_addr(strap_addr), .host_idx(host_idx),
        .host_rd(host_rd), .host_wr(host_wr),
        .rd_hit(rd_hit), .wr_hit(wr_hit), .kind(kind), .psel(psel)
    );

    gpx_readmux #(
        .PORT_W(PORT_W), .NPORTS(NPORTS), .PSEL_W(PSEL_W), .LINES(LINES)
    ) i_readmux (
        .kind(kind), .psel(psel), .in_s(st_q.in_s), .pol(st_q.pol),
        .dir(st_q.dir), .olat(st_q.olat), .cap(st_q.cap), .rd_byte(rd_byte)
    );

    always_comb begin
        st_d      = st_q;
        st_d.in_s = pin_in;

        // R6/R8: a read latches data and resyncs the addressed port state
        if (rd_hit) begin
            st_d.rdata = rd_byte;
            for (int p = 0; p < NPORTS; p++) begin
                if (psel == PSEL_W'(p) && kind == KIND_PORT) begin
                    st_d.port[p*PORT_W +: PORT_W] = st_q.in_s[p*PORT_W +: PORT_W];
                end
            end
        end

        // R3/R4/R10: writable classes; capture and unmapped are dropped
        if (wr_hit) begin
            for (int p = 0; p < NPORTS; p++) begin
                if (psel == PSEL_W'(p)) begin
                    case (kind)
                        KIND_PORT,
                        KIND_OLAT: st_d.olat[p*PORT_W +: PORT_W] = host_wdata;
                        KIND_POL:  st_d.pol[p*PORT_W +: PORT_W]  = host_wdata;
                        KIND_DIR:  st_d.dir[p*PORT_W +: PORT_W]  = host_wdata;
                        default:   ;
                    endcase
                end
            end
        end

        // R7: mismatch of next sample against next port state, inputs only
        st_d.irq = |((st_d.in_s ^ st_d.port) & st_d.dir);

        // R9: snapshot on the assertion edge only
        if (st_d.irq && !st_q.irq) begin
            st_d.cap = st_d.in_s;
        end
    end

    // R1: reset values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dir   <= '1;
        end else begin
            st_q       <= st_d;
        end
    end

    assign pin_oe     = ~st_q.dir;
    assign pin_out    = st_q.olat;
    assign irq_n      = ~st_q.irq;
    assign irq_oe     = st_q.irq;
    assign host_rdata = st_q.rdata;

endmodule

// File: rtl/gpx_checker.sv
module gpx_checker #(
    parameter int                   PORT_W    = 8,
    parameter int                   NPORTS    = 2,
    parameter int                   STRAP_W   = 3,
    parameter int                   ADDR_HI_W = 4,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI   = 4'b0100
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic [STRAP_W-1:0]                        strap_addr,
    input logic [ADDR_HI_W+STRAP_W-1:0]              host_addr,
    input logic [3+((NPORTS>1)?$clog2(NPORTS):1)-1:0] host_idx,
    input logic                                      host_rd,
    input logic                                      host_wr,
    input logic [PORT_W-1:0]                         host_wdata,
    input logic [PORT_W-1:0]                         host_rdata,
    input logic [PORT_W*NPORTS-1:0]                  pin_in,
    input logic [PORT_W*NPORTS-1:0]                  pin_out,
    input logic [PORT_W*NPORTS-1:0]                  pin_oe,
    input logic                                      irq_n
);

    localparam int PSEL_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1;
    localparam int IDX_W     = 3 + PSEL_W;
    localparam int IDX_DIR0  = 3 << PSEL_W;
    localparam int IDX_OLAT1 = (1 << PSEL_W) + 1;
    localparam int IDX_CAP0  = 4 << PSEL_W;

    logic hit;
    assign hit = (host_addr == {ADDR_HI, strap_addr});

    assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit && host_idx == IDX_W'(IDX_DIR0))
        |=> pin_oe[PORT_W-1:0] == ~$past(host_wdata));

    assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit && host_idx == IDX_W'(IDX_OLAT1))
        |=> pin_out[PORT_W +: PORT_W] == $past(host_wdata));

    assert_foreign_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !hit) |=> ($stable(pin_oe) && $stable(pin_out)));

    assert_dead_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit && host_idx >= IDX_W'(IDX_CAP0))
        |=> ($stable(pin_oe) && $stable(pin_out)));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && hit) |=> $stable(host_rdata));

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !host_rd && !host_wr && $stable(pin_in)) |=> $stable(irq_n));

endmodule

bind gpx_core gpx_checker #(
    .PORT_W(PORT_W), .NPORTS(NPORTS), .STRAP_W(STRAP_W),
    .ADDR_HI_W(ADDR_HI_W), .ADDR_HI(ADDR_HI)
) i_gpx_checker (.*);

// File: tb/test_gpx_core.sv
module test_gpx_core;

    localparam logic [6:0] DEV = {4'b0100, 3'b101};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  strap_addr = 3'b101;
    logic [6:0]  host_addr = DEV;
    logic [3:0]  host_idx = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq_n, irq_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state derived from the requirements
    logic [15:0] m_dir = '1, m_olat = '0, m_pol = '0, m_port = '0, m_cap = '0, m_in = '0;
    logic        m_irq = 1'b0;
    logic [7:0]  m_rdata = '0;
    bit          m_rd_now = 0;
    string       m_rd_tag = "R6";

    always #4 clk = ~clk;

    gpx_core i_gpx_core (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr), .host_addr(host_addr),
        .host_idx(host_idx), .host_rd(host_rd), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] ref_read(input logic [3:0] idx);
        int p = int'(idx[0]);
        case (idx[3:1])
            3'd0: return m_in[p*8 +: 8] ^ (m_pol[p*8 +: 8] & m_dir[p*8 +: 8]);
            3'd1: return m_olat[p*8 +: 8];
            3'd2: return m_pol[p*8 +: 8];
            3'd3: return m_dir[p*8 +: 8];
            3'd4: return m_cap[p*8 +: 8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        bit          hit = (host_addr == DEV);
        bit          rd = host_rd && hit;
        bit          wr = host_wr && hit;
        int          p = int'(host_idx[0]);
        logic [2:0]  kind = host_idx[3:1];
        logic [7:0]  rdv = ref_read(host_idx);
        logic        nirq;
        m_rd_now = rd;
        if (rd) begin
            m_rdata = rdv;
            if (kind == 3'd0) begin
                m_port[p*8 +: 8] = m_in[p*8 +: 8];
                m_rd_tag = "R5";
            end else if (kind == 3'd4) m_rd_tag = "R9";
            else if (kind > 3'd4) m_rd_tag = "R10";
            else m_rd_tag = "R6";
        end
        if (wr) begin
            case (kind)
                3'd0, 3'd1: m_olat[p*8 +: 8] = host_wdata;
                3'd2:       m_pol[p*8 +: 8]  = host_wdata;
                3'd3:       m_dir[p*8 +: 8]  = host_wdata;
                default:    ;
            endcase
        end
        m_in = pin_in;
        nirq = |((m_in ^ m_port) & m_dir);
        if (nirq && !m_irq) m_cap = m_in;
        m_irq = nirq;
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R3 pin_oe", pin_oe, ~m_dir);
        check("R4 pin_out", pin_out, m_olat);
        check("R7 irq_n", {15'd0, irq_n}, {15'd0, ~m_irq});
        check("R7 irq_oe", {15'd0, irq_oe}, {15'd0, m_irq});
        if (m_rd_now) check({m_rd_tag, " rdata"}, {8'd0, host_rdata}, {8'd0, m_rdata});
        else          check("R6 rdata hold", {8'd0, host_rdata}, {8'd0, m_rdata});
    endtask

    task automatic xfer(input bit rd, input bit wr, input logic [3:0] idx,
                        input logic [7:0] wd, input logic [6:0] addr);
        host_rd = rd; host_wr = wr; host_idx = idx; host_wdata = wd; host_addr = addr;
        tick();
        host_rd = 0; host_wr = 0; host_addr = DEV;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 pin_out", pin_out, 16'h0000);
        check("R1 irq", {14'd0, irq_n, irq_oe}, 16'h0002);
        check("R1 rdata", {8'd0, host_rdata}, 16'h0000);
        rst_n = 1'b1;
        tick(); tick();
        xfer(1, 0, 4'd8, 8'h00, DEV);
        check("R1 capture", {8'd0, host_rdata}, 16'h0000);

        // R5: polarity on inputs
        xfer(0, 1, 4'd4, 8'hF0, DEV);
        pin_in = 16'h00A5; tick();
        xfer(1, 0, 4'd0, 8'h00, DEV);
        check("R5 inverted read", {8'd0, host_rdata}, 16'h0055);
        check("R8 released", {15'd0, irq_n}, 16'd1);

        // R7/R8/R9: single line change on port 1
        pin_in = 16'h02A5; tick();
        check("R7 asserted", {15'd0, irq_n}, 16'd0);
        xfer(1, 0, 4'd9, 8'h00, DEV);
        check("R9 capture hi", {8'd0, host_rdata}, 16'h0002);
        check("R8 cap read keeps irq", {15'd0, irq_n}, 16'd0);
        xfer(1, 0, 4'd8, 8'h00, DEV);
        check("R9 capture raw", {8'd0, host_rdata}, 16'h00A5);
        xfer(1, 0, 4'd1, 8'h00, DEV);
        check("R8 port read clears", {15'd0, irq_n}, 16'd1);

        // R7: output-direction line does not interrupt
        xfer(0, 1, 4'd6, 8'hEF, DEV);
        pin_in = 16'h02B5; tick(); tick();
        check("R7 output line quiet", {15'd0, irq_n}, 16'd1);

        // R2: foreign address ignored
        xfer(0, 1, 4'd2, 8'h3C, DEV ^ 7'h01);
        check("R2 no write", pin_out, 16'h0000);
        xfer(1, 0, 4'd0, 8'h00, DEV ^ 7'h10);
        check("R2 rdata held", {8'd0, host_rdata}, 16'h0002);

        // R10: unmapped and capture writes
        xfer(0, 1, 4'd12, 8'hFF, DEV);
        xfer(0, 1, 4'd8, 8'hFF, DEV);
        xfer(1, 0, 4'd12, 8'h00, DEV);
        check("R10 unmapped reads 0", {8'd0, host_rdata}, 16'h0000);
        xfer(1, 0, 4'd8, 8'h00, DEV);
        check("R10 capture unwritten", {8'd0, host_rdata}, 16'h00A5);

        // R4 and R3
        xfer(0, 1, 4'd0, 8'h5A, DEV);
        check("R4 port write to latch", pin_out, 16'h005A);
        xfer(0, 1, 4'd7, 8'h0F, DEV);
        check("R3 dir hi", pin_oe, 16'hF010);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom % 8);
            logic [6:0] a = (($urandom % 10) == 0) ? 7'($urandom) : DEV;
            logic [3:0] ix = 4'($urandom);
            if (op < 3)      xfer(1, 0, ix, 8'h00, a);
            else if (op < 5) xfer(0, 1, ix, 8'($urandom), a);
            else if (op < 7) begin
                pin_in = pin_in ^ (16'h1 << ($urandom % 16));
                tick();
            end else tick();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule